// File: doc/BRIEF.md
# Carrier Tracking Loop Filter

This block is the loop filter of a digital automatic-frequency-control loop. Once per symbol it takes a signed frequency-error word and produces a frequency-correction word for a numerically controlled oscillator. The filter is proportional-plus-integral. Each path scales the error by a power of two that is set by a 5-bit shift code. The integral path then adds the scaled error into a saturating accumulator. The correction word is the proportional term plus the integer part of the accumulator, saturated to the output width.

Software-style control inputs select the two shift codes and switch each path on or off. Another input adds half an LSB to the integrator every symbol, which cancels the downward bias of two's-complement truncation. A freeze input pins the correction word, and with it the oscillator frequency, at its present value. The filter changes state only on a one-cycle symbol strobe. The new correction word appears one clock after that strobe.

Top module: `carrier_loop_filter`

## Requirements
- R1: After reset, `freqOut` is 0 and the integrator holds 0.
- R2: With the integral path off, a strobe with error e gives `freqOut` = e·2^g1 one clock after the strobe. Here g1 is the unsigned value of `k1Gain[4:0]`, so code 0 is a gain of 1 and code 21 is a gain of 2^21.
- R3: A shift code from 22 to 31, on either path, acts exactly like code 21.
- R4: With `k1On` low, the proportional path contributes 0 to `freqOut`.
- R5: A scaled term beyond the signed range of `freqOut` is clamped. It goes to +(2^(OUT_W-1)−1) when the positive limit is exceeded and to −2^(OUT_W-1) when the negative limit is exceeded.
- R6: With `k2On` high, each strobe adds the saturated e·2^g2 to the integrator. `freqOut` then includes the integrator value, rounded toward minus infinity.
- R7: The integrator keeps one fractional bit. With `halfCarry` high, each strobe also adds 1/2 LSB, so with zero error the integer part rises by 1 every two symbols.
- R8: While `k2On` is low, the integrator is cleared on every clock and stays at 0. This happens whether or not a strobe occurs.
- R9: While `freeze` is high, `freqOut` and the integrator both hold their values across strobes. When the freeze ends, the filter continues from the held integrator value.
- R10: `freqOut` changes only on the clock edge that samples `symStrobe` high. Changes of `errIn` between strobes have no effect.
- R11: The integrator saturates at its limits instead of wrapping. The sum of the two paths saturates to the output range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| symStrobe | input | 1 | One-cycle pulse per symbol; marks `errIn` as valid |
| errIn | input | ERR_W | Signed frequency-error word |
| k1Gain | input | 5 | Proportional shift code (0..21, higher codes clamp to 21) |
| k1On | input | 1 | Proportional path enable |
| k2Gain | input | 5 | Integral shift code (0..21, higher codes clamp to 21) |
| k2On | input | 1 | Integral path enable; low clears the integrator |
| halfCarry | input | 1 | Adds 1/2 LSB to the integrator each symbol |
| freeze | input | 1 | Holds the output and the integrator |
| freqOut | output | OUT_W | Signed frequency-correction word |

## Verification
Two controls can act in the same cycle: the freeze and the integral-path disable. The bench builds up a non-zero integrator, raises `freeze`, and then drops `k2On` while the freeze is still active, sending strobes with large errors. The expected result is that `freqOut` does not move, because the freeze wins for the output. The integrator must still be cleared, because the clear wins for the accumulator. This is judged after the freeze is lifted, `k2On` is restored, and a zero-error symbol is sent: that symbol must give 0.

// File: rtl/loop_filt_pkg.sv
package loop_filt_pkg;

  localparam int GAIN_CODE_W = 5;

  // Per-cycle commands from the control module to the datapath.
  typedef struct packed {
    logic update;    // take a new symbol into output and integrator
    logic clearAcc;  // force integrator to zero
    logic addHalf;   // add half an LSB to the integrator input
    logic useK1;     // proportional term participates
  } lfStrobes_t;

endpackage

// File: rtl/lf_gain_scale.sv
module lf_gain_scale #(
  parameter int ERR_W     = 12,
  parameter int OUT_W     = 24,
  parameter int MAX_SHIFT = 21
) (
  input  logic signed [ERR_W-1:0]                    errIn,
  input  logic        [loop_filt_pkg::GAIN_CODE_W-1:0] shift,
  output logic signed [OUT_W-1:0]                    scaled
);

  localparam int WIDE_W = ERR_W + MAX_SHIFT + 1;
  localparam logic signed [WIDE_W-1:0] POS_LIM = WIDE_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [WIDE_W-1:0] NEG_LIM = -POS_LIM - WIDE_W'(1);

  logic signed [WIDE_W-1:0] errExt;
  logic signed [WIDE_W-1:0] shifted;

  assign errExt  = {{(WIDE_W-ERR_W){errIn[ERR_W-1]}}, errIn};
  assign shifted = errExt <<< shift;

  always_comb begin
    if (shifted > POS_LIM)      scaled = POS_LIM[OUT_W-1:0];
    else if (shifted < NEG_LIM) scaled = NEG_LIM[OUT_W-1:0];
    else                        scaled = shifted[OUT_W-1:0];
  end

endmodule

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import loop_filt_pkg::*;
#(
  parameter int MAX_SHIFT = 21
) (
  input  logic                   symStrobe,
  input  logic                   freeze,
  input  logic                   k1On,
  input  logic                   k2On,
  input  logic                   halfCarry,
  input  logic [GAIN_CODE_W-1:0] k1Gain,
  input  logic [GAIN_CODE_W-1:0] k2Gain,
  output lfStrobes_t             strb,
  output logic [GAIN_CODE_W-1:0] k1Shift,
  output logic [GAIN_CODE_W-1:0] k2Shift
);

  localparam logic [GAIN_CODE_W-1:0] SHIFT_CAP = GAIN_CODE_W'(MAX_SHIFT);

  function automatic logic [GAIN_CODE_W-1:0] capShift(input logic [GAIN_CODE_W-1:0] code);
    return (code > SHIFT_CAP) ? SHIFT_CAP : code;
  endfunction

  always_comb begin
    strb.update   = symStrobe && !freeze;
    strb.clearAcc = !k2On;
    strb.addHalf  = halfCarry;
    strb.useK1    = k1On;
    k1Shift       = capShift(k1Gain);
    k2Shift       = capShift(k2Gain);
  end

endmodule

// File: rtl/lf_datapath.sv
module lf_datapath
  import loop_filt_pkg::*;
#(
  parameter int ERR_W     = 12,
  parameter int OUT_W     = 24,
  parameter int MAX_SHIFT = 21
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lfStrobes_t              strb,
  input  logic signed [ERR_W-1:0] errIn,
  input  logic [GAIN_CODE_W-1:0]  k1Shift,
  input  logic [GAIN_CODE_W-1:0]  k2Shift,
  output logic signed [OUT_W-1:0] freqOut
);

  localparam int ACC_W = OUT_W + 1;   // one fractional bit
  localparam int SUM_W = ACC_W + 2;
  localparam int OSUM_W = OUT_W + 1;
  localparam logic signed [SUM_W-1:0]  ACC_POS = SUM_W'((64'sd1 <<< (ACC_W-1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0]  ACC_NEG = -ACC_POS - SUM_W'(1);
  localparam logic signed [OSUM_W-1:0] OUT_POS = OSUM_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [OSUM_W-1:0] OUT_NEG = -OUT_POS - OSUM_W'(1);

  logic [GAIN_CODE_W-1:0]  shiftArr  [2];
  logic signed [OUT_W-1:0] scaledArr [2];

  assign shiftArr[0] = k1Shift;
  assign shiftArr[1] = k2Shift;

  for (genvar p = 0; p < 2; p++) begin : g_path
    lf_gain_scale #(
      .ERR_W    (ERR_W),
      .OUT_W    (OUT_W),
      .MAX_SHIFT(MAX_SHIFT)
    ) i_scale (
      .errIn (errIn),
      .shift (shiftArr[p]),
      .scaled(scaledArr[p])
    );
  end

  logic signed [OUT_W-1:0]  k1Term;
  logic signed [OUT_W-1:0]  k2In;
  logic signed [ACC_W-1:0]  acc;
  logic signed [SUM_W-1:0]  accExt, incExt, carryExt, accSum;
  logic signed [ACC_W-1:0]  accNext, accSel;
  logic signed [OUT_W-1:0]  accInt;
  logic signed [OSUM_W-1:0] outSum;
  logic signed [OUT_W-1:0]  outNext;

  always_comb begin
    k1Term   = strb.useK1 ? scaledArr[0] : '0;
    k2In     = scaledArr[1];
    accExt   = {{2{acc[ACC_W-1]}}, acc};
    incExt   = {{2{k2In[OUT_W-1]}}, k2In, 1'b0};
    carryExt = {{(SUM_W-1){1'b0}}, strb.addHalf};
    accSum   = accExt + incExt + carryExt;
    if (accSum > ACC_POS)      accNext = ACC_POS[ACC_W-1:0];
    else if (accSum < ACC_NEG) accNext = ACC_NEG[ACC_W-1:0];
    else                       accNext = accSum[ACC_W-1:0];
    accSel = strb.clearAcc ? '0 : accNext;
    accInt = accSel[ACC_W-1:1];
    outSum = {k1Term[OUT_W-1], k1Term} + {accInt[OUT_W-1], accInt};
    if (outSum > OUT_POS)      outNext = OUT_POS[OUT_W-1:0];
    else if (outSum < OUT_NEG) outNext = OUT_NEG[OUT_W-1:0];
    else                       outNext = outSum[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              acc <= '0;
    else if (strb.clearAcc) acc <= '0;
    else if (strb.update)   acc <= accNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            freqOut <= '0;
    else if (strb.update) freqOut <= outNext;
  end

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.update |=> $stable(freqOut)); // R10

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAcc |=> (acc == '0)); // R8

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && !strb.clearAcc && !k2In[OUT_W-1]) |=> (acc >= $past(acc))); // R11

endmodule

// File: rtl/carrier_loop_filter.sv
module carrier_loop_filter
  import loop_filt_pkg::*;
#(
  parameter int ERR_W     = 12,
  parameter int OUT_W     = 24,
  parameter int MAX_SHIFT = 21
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    symStrobe,
  input  logic signed [ERR_W-1:0] errIn,
  input  logic [4:0]              k1Gain,
  input  logic                    k1On,
  input  logic [4:0]              k2Gain,
  input  logic                    k2On,
  input  logic                    halfCarry,
  input  logic                    freeze,
  output logic signed [OUT_W-1:0] freqOut
);

  lfStrobes_t             strb;
  logic [GAIN_CODE_W-1:0] k1Shift, k2Shift;

  lf_ctrl #(.MAX_SHIFT(MAX_SHIFT)) i_ctrl (
    .symStrobe(symStrobe),
    .freeze   (freeze),
    .k1On     (k1On),
    .k2On     (k2On),
    .halfCarry(halfCarry),
    .k1Gain   (k1Gain),
    .k2Gain   (k2Gain),
    .strb     (strb),
    .k1Shift  (k1Shift),
    .k2Shift  (k2Shift)
  );

  lf_datapath #(
    .ERR_W    (ERR_W),
    .OUT_W    (OUT_W),
    .MAX_SHIFT(MAX_SHIFT)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .errIn  (errIn),
    .k1Shift(k1Shift),
    .k2Shift(k2Shift),
    .freqOut(freqOut)
  );

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> $stable(freqOut)); // R9

  AST_K1_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (symStrobe && !freeze && !k1On && !k2On) |=> (freqOut == '0)); // R4

  AST_NO_SIGN_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (symStrobe && !freeze && k1On && !k2On && !errIn[ERR_W-1]) |=> !freqOut[OUT_W-1]); // R5

endmodule

// File: tb/test_carrier_loop_filter.sv
module test_carrier_loop_filter;

  localparam int ERR_W = 12;
  localparam int OUT_W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic symStrobe = 1'b0;
  logic signed [ERR_W-1:0] errIn = '0;
  logic [4:0] k1Gain = '0;
  logic k1On = 1'b0;
  logic [4:0] k2Gain = '0;
  logic k2On = 1'b0;
  logic halfCarry = 1'b0;
  logic freeze = 1'b0;
  logic signed [OUT_W-1:0] freqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  longint mAcc = 0;  // half-LSB units
  longint mOut = 0;

  carrier_loop_filter #(.ERR_W(ERR_W), .OUT_W(OUT_W)) i_carrier_loop_filter (
    .clk(clk), .rstN(rstN), .symStrobe(symStrobe), .errIn(errIn),
    .k1Gain(k1Gain), .k1On(k1On), .k2Gain(k2Gain), .k2On(k2On),
    .halfCarry(halfCarry), .freeze(freeze), .freqOut(freqOut)
  );

  always #4 clk = ~clk;

  function automatic longint satv(longint v, int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    longint lo = -hi - 1;
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic longint scaleM(int e, int code);
    int g = (code > 21) ? 21 : code;
    return satv(longint'(e) <<< g, OUT_W);
  endfunction

  task automatic check(string req, longint exp);
    longint act = longint'(freqOut);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: freqOut=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; symStrobe = 1'b0; errIn = '0; k1Gain = '0; k1On = 1'b0;
    k2Gain = '0; k2On = 1'b0; halfCarry = 1'b0; freeze = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mAcc = 0; mOut = 0;
    @(negedge clk);
  endtask

  task automatic symbol(int e);
    longint k1t;
    @(negedge clk);
    errIn = ERR_W'(e);
    symStrobe = 1'b1;
    @(negedge clk);
    symStrobe = 1'b0;
    k1t = k1On ? scaleM(e, k1Gain) : 0;
    if (!k2On) mAcc = 0;
    else if (!freeze) mAcc = satv(mAcc + 2 * scaleM(e, k2Gain) + longint'(halfCarry), OUT_W + 1);
    if (!freeze) mOut = satv(k1t + (mAcc >>> 1), OUT_W);
  endtask

  task automatic testReset();
    doReset();
    check("R1 reset output", 0);
    k2On = 1'b1;
    symbol(0);
    check("R1 integrator zero after reset", 0);
  endtask

  task automatic testProportional();
    doReset();
    k1On = 1'b1; k1Gain = 5'd3;
    symbol(5);   check("R2 +5<<3", 40);
    symbol(-7);  check("R2 -7<<3", -56);
    k1Gain = 5'd0;
    symbol(-2048); check("R2 gain code 0", -2048);
    @(negedge clk);
    errIn = 12'sd1000;
    repeat (3) @(negedge clk);
    check("R10 no strobe, no change", -2048);
  endtask

  task automatic testGainCap();
    doReset();
    k1On = 1'b1; k1Gain = 5'd25;
    symbol(1);  check("R3 k1 code 25 acts as 21", 2097152);
    k1Gain = 5'd31;
    symbol(-1); check("R3 k1 code 31 acts as 21", -2097152);
    k1On = 1'b0; k2On = 1'b1; k2Gain = 5'd30;
    symbol(1);  check("R3 k2 code 30 acts as 21", 2097152);
  endtask

  task automatic testSaturate();
    doReset();
    k1On = 1'b1; k1Gain = 5'd21;
    symbol(100);  check("R5 positive clamp", 8388607);
    symbol(-100); check("R5 negative clamp", -8388608);
    k1Gain = 5'd12;
    symbol(2047); check("R5 just below limit", 2047 * 4096);
  endtask

  task automatic testK1Off();
    doReset();
    k1On = 1'b0; k1Gain = 5'd4;
    symbol(50); check("R4 k1 off contributes zero", 0);
  endtask

  task automatic testIntegrator();
    doReset();
    k2On = 1'b1; k2Gain = 5'd2;
    symbol(3);  check("R6 integrate step 1", 12);
    symbol(3);  check("R6 integrate step 2", 24);
    symbol(-10); check("R6 integrate negative", -16);
    k1On = 1'b1; k1Gain = 5'd1;
    symbol(2);  check("R6 proportional plus integral", mOut);
    check("R6 sum value", 4 + (-8));
  endtask

  task automatic testHalfCarry();
    doReset();
    k2On = 1'b1; halfCarry = 1'b1;
    symbol(0); check("R7 half carry 1", 0);
    symbol(0); check("R7 half carry 2", 1);
    symbol(0); check("R7 half carry 3", 1);
    symbol(0); check("R7 half carry 4", 2);
    halfCarry = 1'b0; k2Gain = 5'd0;
    symbol(-3); check("R7 floor of negative", mOut);
    check("R7 floor value", -1);
  endtask

  task automatic testK2Clear();
    doReset();
    k2On = 1'b1; k2Gain = 5'd5;
    symbol(7); check("R8 accumulate before clear", 224);
    @(negedge clk); k2On = 1'b0;
    @(negedge clk); k2On = 1'b1;
    mAcc = 0;
    symbol(0); check("R8 integrator cleared without strobe", 0);
    k2On = 1'b0;
    symbol(9); check("R8 held at zero while off", 0);
  endtask

  task automatic testFreeze();
    doReset();
    k2On = 1'b1; k2Gain = 5'd3;
    symbol(10); check("R9 before freeze", 80);
    freeze = 1'b1;
    symbol(500);  check("R9 frozen output", 80);
    symbol(-700); check("R9 still frozen", 80);
    freeze = 1'b0;
    symbol(0); check("R9 no windup after freeze", 80);
  endtask

  task automatic testAccSat();
    doReset();
    k2On = 1'b1; k2Gain = 5'd21;
    for (int i = 0; i < 6; i++) symbol(2047);
    check("R11 integrator saturates high", 8388607);
    k2Gain = 5'd0;
    symbol(-1); check("R11 no wrap after saturation", 8388606);
    k1On = 1'b1; k1Gain = 5'd21;
    symbol(1); check("R11 output sum saturates", 8388607);
  endtask

  task automatic testFreezeAndClear();
    doReset();
    k2On = 1'b1; k2Gain = 5'd4;
    symbol(20); check("R9 integrator loaded", 320);
    freeze = 1'b1;
    @(negedge clk); k2On = 1'b0;
    symbol(1000); check("R9 freeze wins for output", 320);
    freeze = 1'b0; k2On = 1'b1;
    symbol(0); check("R8 clear wins for integrator", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testProportional();
    testGainCap();
    testSaturate();
    testK1Off();
    testIntegrator();
    testHalfCarry();
    testK2Clear();
    testFreeze();
    testAccSat();
    testFreezeAndClear();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule